// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This control unit carries out the hardware steps of taking and leaving an exception on a 16-bit, word-addressed processor core. It watches a maskable interrupt line, a non-maskable interrupt line and six trap request lines from the datapath. When one of them is accepted, it saves the status word and the program counter on a stack that grows downward. It then reads the handler address from a dispatch table held in memory and hands that address to the fetch unit.

On a return request it reads the program counter and the status word back from the stack. It gives both to the core and releases the two stack words. While a sequence runs, the unit holds a busy output high so that the pipeline stays serialized. The stack pointer and the dispatch table base are internal registers, and their start values are parameters. Memory is reached through one word-wide port. A read returns its data one cycle after the address is presented.

Top module: `exc_seq`

## Requirements
- R1: After reset, busy, mem_we, mem_re, pc_load and psr_we are all 0 until a request arrives.
- R2: An accepted exception request, sampled at a clock edge while idle, writes the captured status word to address SP-1 in the next cycle. In the cycle after that it writes the captured PC to address SP-2. SP starts at ISP_INIT.
- R3: The third cycle of an entry reads address BASE+vector. The vector numbers are: non-maskable 1; trap_req bit 0..5 gives 5..10; maskable 16. In the fourth cycle pc_load is 1 and pc_new equals the word read.
- R4: Priority is non-maskable first, then traps, then maskable. Among the traps, the lowest set bit of trap_req wins.
- R5: The maskable interrupt is accepted only when psr_in bit 9 is 1. Otherwise it is ignored, and busy and mem_we stay 0.
- R6: In the status-push cycle, psr_we is 1 and psr_new equals the captured status word with bit 9 cleared.
- R7: Each entry lowers SP by 2, so nested entries stack below one another.
- R8: A return reads address SP, then SP+1. In the third cycle pc_load is 1 with the first word, and psr_we is 1 with the second word. SP rises by 2.
- R9: busy is 1 from the first sequence cycle through the pc_load cycle, and 0 in the cycle after. Requests presented while busy are dropped. If an exception request and a return request arrive together, the exception is taken.
- R10: mem_we and mem_re are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| trap_req | input | 6 | Trap requests, bit 0 has the highest priority |
| ret_req | input | 1 | Return-from-exception request |
| cur_pc | input | 16 | PC to be saved on entry |
| psr_in | input | 16 | Current status word, bit 9 is the interrupt enable |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_re |
| busy | output | 1 | Sequence in progress, pipeline serialized |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| pc_load | output | 1 | Redirect fetch to pc_new |
| pc_new | output | 16 | New PC |
| psr_we | output | 1 | Load status word from psr_new |
| psr_new | output | 16 | New status word |

## Verification
The bench first takes each request source alone. Then it sweeps all 128 combinations of the non-maskable and trap lines, with the maskable line also raised, against an arithmetic priority model. This separates an error in vector numbering from an error in priority order. The maskable line is also held with the enable bit clear, once with the other status bits at zero and once with all of them set, to show that only bit 9 gates acceptance. Two nested entries followed by two returns test the descending stack pointer and the order in which saved words come back. A return request pulsed during a busy entry must leave no trace.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int W         = 16,
  parameter int I_BIT     = 9,
  parameter int NTRAP     = 6,
  parameter logic [15:0] ISP_INIT  = 16'h0080,
  parameter logic [15:0] BASE_INIT = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             nmi,
  input  logic [NTRAP-1:0] trap_req,
  input  logic             ret_req,
  input  logic [W-1:0]     cur_pc,
  input  logic [W-1:0]     psr_in,
  input  logic [W-1:0]     mem_rdata,
  output logic             busy,
  output logic             mem_we,
  output logic             mem_re,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  output logic             pc_load,
  output logic [W-1:0]     pc_new,
  output logic             psr_we,
  output logic [W-1:0]     psr_new
);
  localparam logic [W-1:0] VEC_NMI   = W'(1);
  localparam logic [W-1:0] VEC_TRAP0 = W'(5);
  localparam logic [W-1:0] VEC_IRQ   = W'(16);

  typedef enum logic [2:0] {
    S_IDLE, S_PSH_PSR, S_PSH_PC, S_DISP, S_ENT_LD, S_POP_PC, S_POP_PSR, S_RET_LD
  } st_t;

  st_t          st;
  logic [W-1:0] isp, pc_cap, psr_cap, vec, sel_vec;
  logic         take_exc;

  assign take_exc = nmi | (|trap_req) | (irq & psr_in[I_BIT]);

  always_comb begin
    sel_vec = VEC_IRQ;
    for (int i = NTRAP-1; i >= 0; i--)
      if (trap_req[i]) sel_vec = VEC_TRAP0 + W'(i);
    if (nmi) sel_vec = VEC_NMI;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      isp     <= ISP_INIT;
      pc_cap  <= '0;
      psr_cap <= '0;
      vec     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (take_exc) begin
            pc_cap  <= cur_pc;
            psr_cap <= psr_in;
            vec     <= sel_vec;
            st      <= S_PSH_PSR;
          end else if (ret_req) begin
            st <= S_POP_PC;
          end
        end
        S_PSH_PSR: st <= S_PSH_PC;
        S_PSH_PC: begin
          isp <= isp - W'(2);
          st  <= S_DISP;
        end
        S_DISP:   st <= S_ENT_LD;
        S_ENT_LD: st <= S_IDLE;
        S_POP_PC: st <= S_POP_PSR;
        S_POP_PSR: begin
          pc_cap <= mem_rdata;
          st     <= S_RET_LD;
        end
        S_RET_LD: begin
          isp <= isp + W'(2);
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign mem_we  = (st == S_PSH_PSR) || (st == S_PSH_PC);
  assign mem_re  = (st == S_DISP) || (st == S_POP_PC) || (st == S_POP_PSR);
  assign pc_load = (st == S_ENT_LD) || (st == S_RET_LD);
  assign psr_we  = (st == S_PSH_PSR) || (st == S_RET_LD);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    pc_new    = mem_rdata;
    psr_new   = psr_cap & ~(W'(1) << I_BIT);
    case (st)
      S_PSH_PSR: begin mem_addr = isp - W'(1); mem_wdata = psr_cap; end
      S_PSH_PC:  begin mem_addr = isp - W'(2); mem_wdata = pc_cap;  end
      S_DISP:    mem_addr = BASE_INIT + vec;
      S_POP_PC:  mem_addr = isp;
      S_POP_PSR: mem_addr = isp + W'(1);
      S_RET_LD:  begin pc_new = pc_cap; psr_new = mem_rdata; end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int W     = 16,
  parameter int I_BIT = 9,
  parameter int NTRAP = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             nmi,
  input logic [NTRAP-1:0] trap_req,
  input logic             ret_req,
  input logic [W-1:0]     psr_in,
  input logic             busy,
  input logic             mem_we,
  input logic             mem_re,
  input logic [W-1:0]     mem_addr,
  input logic             pc_load,
  input logic             psr_we,
  input logic [W-1:0]     psr_new
);
  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R2
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == $past(mem_addr) - W'(1)));

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq && !psr_in[I_BIT] && !nmi && trap_req == '0 && !ret_req) |=> !busy);

  // R9
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  // R6
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && mem_we) |-> !psr_new[I_BIT]);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re || pc_load || psr_we));
endmodule

bind exc_seq exc_seq_chk #(.W(W), .I_BIT(I_BIT), .NTRAP(NTRAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .nmi(nmi), .trap_req(trap_req),
  .ret_req(ret_req), .psr_in(psr_in), .busy(busy), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .pc_load(pc_load),
  .psr_we(psr_we), .psr_new(psr_new)
);

// File: tb/exc_seq_tb.sv
module exc_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ISP0  = 16'h0080;
  localparam logic [15:0] BASE0 = 16'h0040;

  logic clk = 0, rst_n = 0;
  logic irq = 0, nmi = 0, ret_req = 0;
  logic [5:0] trap_req = '0;
  logic [15:0] cur_pc = '0, psr_in = '0, mem_rdata;
  logic busy, mem_we, mem_re, pc_load, psr_we;
  logic [15:0] mem_addr, mem_wdata, pc_new, psr_new;
  logic [15:0] mem [0:255];
  logic [15:0] isp_m;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .nmi(nmi), .trap_req(trap_req),
    .ret_req(ret_req), .cur_pc(cur_pc), .psr_in(psr_in), .mem_rdata(mem_rdata),
    .busy(busy), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_new(pc_new),
    .psr_we(psr_we), .psr_new(psr_new)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  function automatic logic [15:0] disp(input int v);
    return 16'hA000 | 16'(v << 4);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_entry(input logic n, input logic [5:0] t, input logic q,
                          input logic [15:0] pc, input logic [15:0] psr,
                          input int v, input logic poke_ret, input logic with_ret);
    nmi = n; trap_req = t; irq = q; cur_pc = pc; psr_in = psr; ret_req = with_ret;
    @(posedge clk); @(negedge clk);
    nmi = 0; trap_req = '0; irq = 0; ret_req = 0; psr_in = 16'hFFFF; cur_pc = 16'hDEAD;
    chk(mem_we && !mem_re && mem_addr == isp_m - 16'd1, "R2 psr push addr", mem_addr, isp_m - 16'd1);
    chk(mem_wdata == psr, "R2 psr push data", mem_wdata, psr);
    chk(psr_we && psr_new == (psr & ~16'h0200), "R6 ie cleared", psr_new, psr & ~16'h0200);
    chk(busy, "R9 busy in entry", 16'(busy), 16'd1);
    if (poke_ret) ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    chk(mem_we && !mem_re && mem_addr == isp_m - 16'd2, "R7 pc push addr", mem_addr, isp_m - 16'd2);
    chk(mem_wdata == pc, "R2 pc push data", mem_wdata, pc);
    @(negedge clk);
    chk(mem_re && !mem_we && mem_addr == BASE0 + 16'(v), "R3/R4 dispatch addr", mem_addr, BASE0 + 16'(v));
    @(negedge clk);
    chk(pc_load && pc_new == disp(v), "R3 handler pc", pc_new, disp(v));
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re, "R9 idle after entry", 16'(busy), 16'd0);
    isp_m = isp_m - 16'd2;
  endtask

  task automatic do_return(input logic [15:0] pc, input logic [15:0] psr);
    ret_req = 1;
    @(posedge clk); @(negedge clk);
    ret_req = 0;
    chk(mem_re && !mem_we && mem_addr == isp_m, "R8 pop pc addr", mem_addr, isp_m);
    @(negedge clk);
    chk(mem_re && mem_addr == isp_m + 16'd1, "R8 pop psr addr", mem_addr, isp_m + 16'd1);
    @(negedge clk);
    chk(pc_load && pc_new == pc, "R8 restored pc", pc_new, pc);
    chk(psr_we && psr_new == psr, "R8 restored psr", psr_new, psr);
    @(negedge clk);
    chk(!busy, "R9 idle after return", 16'(busy), 16'd0);
    isp_m = isp_m + 16'd2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int v = 0; v < 32; v++) mem[BASE0[7:0] + v] = disp(v);
    isp_m = ISP0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && !mem_re && !pc_load && !psr_we, "R1 reset quiet", 16'(busy), 16'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_we && !mem_re && !pc_load && !psr_we, "R1 idle after reset", 16'(busy), 16'd0);

    do_entry(1, 6'h0, 0, 16'h1234, 16'h0200, 1, 0, 0);
    do_return(16'h1234, 16'h0200);
    for (int b = 0; b < 6; b++) begin
      do_entry(0, 6'(1 << b), 0, 16'h2000 + 16'(b), 16'h0005, 5 + b, 0, 0);
      do_return(16'h2000 + 16'(b), 16'h0005);
    end
    do_entry(0, 6'h0, 1, 16'h3000, 16'h0201, 16, 1, 0);
    do_return(16'h3000, 16'h0201);

    // R5: masked irq
    for (int k = 0; k < 2; k++) begin
      irq = 1; psr_in = (k == 0) ? 16'h0000 : 16'hFDFF;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(!busy && !mem_we, "R5 masked irq ignored", 16'(busy), 16'd0);
      end
      irq = 0;
    end

    // R4 sweep
    for (int m = 0; m < 128; m++) begin
      int ev;
      ev = 16;
      for (int b = 5; b >= 0; b--) if (m[b]) ev = 5 + b;
      if (m[6]) ev = 1;
      do_entry(m[6], 6'(m), 1, 16'h1000 + 16'(m * 3), 16'h0200 | 16'(m), ev, 0, (m % 5) == 0);
      do_return(16'h1000 + 16'(m * 3), 16'h0200 | 16'(m));
    end

    // R7 nesting
    do_entry(1, 6'h0, 0, 16'h1111, 16'h0201, 1, 0, 0);
    chk(isp_m == ISP0 - 16'd2, "R7 model depth", isp_m, ISP0 - 16'd2);
    do_entry(0, 6'h20, 0, 16'h2222, 16'h0203, 10, 0, 0);
    do_return(16'h2222, 16'h0203);
    do_return(16'h1111, 16'h0201);
    // R10 spot check while idle
    chk(!(mem_we && mem_re), "R10 strobes exclusive", 16'(mem_re), 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule